// File: doc/BRIEF.md
# Result-Latency Scoreboard with Wide-Vector Forwarding

This block decides whether an instruction may issue by tracking how many cycles remain until each destination register's result can be consumed. Every tracked register (32 integer, 32 vector) owns a pair of down-counters. When an instruction issues, its write port loads the destination's counters from a per-class latency table. Each cycle the counters count toward zero, and a register reads as ready at zero.

Readiness depends on both sides of the dependency. A 128-bit vector producer in the move, add or multiply family hands its result to a consumer of one of those three 128-bit families one cycle early. A second "forward" counter, loaded with the shortened latency, serves such consumers. Every other consumer waits for the full counter. The check port takes the consumer's class and up to `NUM_SRC` source registers, each with a valid bit, and raises `stall` while any valid source is still pending. The check port sees the counter state before any write presented in the same cycle.

Top module: `sb_scoreboard`

## Requirements
- R1: Class codes and full latencies for scalar work: 0 simple ALU/shift/move = 1, 1 shifted/extended arithmetic or conditional select = 2, 2 integer multiply/CRC = 4, 3 integer load = 3, 4 64-bit FP/vector load = 4. A consumer checked k cycles after the producer's write edge stalls exactly while k is below the latency.
- R2: Floating-point class codes and full latencies: 5 FP add = 4, 6 FP multiply/multiply-accumulate = 6, 7 FP compare = 3, 8 FP/integer conversion = 6.
- R3: Vector class codes and full latencies: 9 narrow move = 2, 10 wide move = 3, 11 narrow add = 4, 12 wide add = 5, 13 narrow multiply/shift = 6, 14 wide multiply/shift = 7. Code 15 is unused and behaves as latency 1.
- R4: When both the producer and the consumer are wide classes (10, 12, 14), the wait is the full latency minus one: 2, 4 or 6 cycles.
- R5: A wide producer seen by a non-wide consumer, and a non-wide producer seen by a wide consumer, use the full latency.
- R6: A write to integer register 0 never makes it pending. Vector register 0 is tracked normally.
- R7: A write to a register that is still pending replaces its remaining wait with the new class's latency, whether shorter or longer.
- R8: `stall` is the OR over sources whose valid bit is set. A pending register named by an invalid source has no effect.
- R9: After reset every register is ready.
- R10: Register address bit 5 selects the file (0 integer, 1 vector) and bits 4:0 the index. The two files are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_cls | input | 4 | Class code of the instruction being checked |
| chk_src_vld | input | NUM_SRC | Per-source valid |
| chk_src_reg | input | NUM_SRC x 6 | Per-source register address {file, index} |
| wr_en | input | 1 | Issue of a producer this cycle |
| wr_reg | input | 6 | Destination register address {file, index} |
| wr_cls | input | 4 | Class code of the producer |
| stall | output | 1 | High while any valid source is pending |

## Verification
The hardest condition to reach is the one where the two counters of a register disagree. This happens only for a wide producer checked by a wide consumer, and only in the single cycle where the forward counter has reached zero but the full counter has not. The bench writes every producer class and checks it against every consumer class at each cycle offset from 0 to 8 after the write. This sweep places a check in that one-cycle window for all three wide producers. Overwrites of a still-pending register, in both directions, are driven back to back so that the reload lands on a non-zero counter.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int LAT_W = 3;
    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CL_ALU    = 4'd0,
        CL_ARX    = 4'd1,
        CL_IMUL   = 4'd2,
        CL_LD     = 4'd3,
        CL_VLD    = 4'd4,
        CL_FADD   = 4'd5,
        CL_FMUL   = 4'd6,
        CL_FCMP   = 4'd7,
        CL_FCVT   = 4'd8,
        CL_VMOV   = 4'd9,
        CL_VMOV_W = 4'd10,
        CL_VADD   = 4'd11,
        CL_VADD_W = 4'd12,
        CL_VMUL   = 4'd13,
        CL_VMUL_W = 4'd14,
        CL_NONE   = 4'd15
    } op_class_e;

    function automatic logic [LAT_W-1:0] full_lat(op_class_e c);
        case (c)
            CL_ALU:    return 3'd1;
            CL_ARX:    return 3'd2;
            CL_IMUL:   return 3'd4;
            CL_LD:     return 3'd3;
            CL_VLD:    return 3'd4;
            CL_FADD:   return 3'd4;
            CL_FMUL:   return 3'd6;
            CL_FCMP:   return 3'd3;
            CL_FCVT:   return 3'd6;
            CL_VMOV:   return 3'd2;
            CL_VMOV_W: return 3'd3;
            CL_VADD:   return 3'd4;
            CL_VADD_W: return 3'd5;
            CL_VMUL:   return 3'd6;
            CL_VMUL_W: return 3'd7;
            default:   return 3'd1;
        endcase
    endfunction

    function automatic logic is_wide(op_class_e c);
        return (c == CL_VMOV_W) || (c == CL_VADD_W) || (c == CL_VMUL_W);
    endfunction

    // Wait seen by a wide consumer of this producer.
    function automatic logic [LAT_W-1:0] fwd_lat(op_class_e c);
        case (c)
            CL_VMOV_W: return 3'd2;
            CL_VADD_W: return 3'd4;
            CL_VMUL_W: return 3'd6;
            default:   return full_lat(c);
        endcase
    endfunction

endpackage

// File: rtl/sb_reg_timer.sv
module sb_reg_timer
    import sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LAT_W-1:0] lat_full,
    input  logic [LAT_W-1:0] lat_fwd,
    output logic [LAT_W-1:0] cnt_full,
    output logic [LAT_W-1:0] cnt_fwd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_full <= '0;
            cnt_fwd  <= '0;
        end else if (load) begin
            cnt_full <= lat_full;
            cnt_fwd  <= lat_fwd;
        end else begin
            if (cnt_full != '0) cnt_full <= cnt_full - 1'b1;
            if (cnt_fwd  != '0) cnt_fwd  <= cnt_fwd  - 1'b1;
        end
    end

    assert_fwd_not_later_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_fwd <= cnt_full);

    assert_count_down_R1: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_full != '0) |=> cnt_full == $past(cnt_full) - 1'b1);

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_full == $past(lat_full));

endmodule

// File: rtl/sb_src_check.sv
module sb_src_check
    import sb_pkg::*;
#(
    parameter int REG_W   = 6,
    parameter int NUM_ENT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_vld,
    input  logic [REG_W-1:0] src_reg,
    input  logic             cons_wide,
    input  logic [LAT_W-1:0] cnt_full [NUM_ENT],
    input  logic [LAT_W-1:0] cnt_fwd  [NUM_ENT],
    output logic             busy
);

    logic [LAT_W-1:0] sel_cnt;

    always_comb begin
        sel_cnt = cons_wide ? cnt_fwd[src_reg] : cnt_full[src_reg];
        busy    = src_vld && (sel_cnt != '0);
    end

    assert_invalid_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !src_vld |-> !busy);

    assert_int_zero_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (src_reg == '0) |-> !busy);

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int NUM_SRC = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [CLS_W-1:0]               chk_cls,
    input  logic [NUM_SRC-1:0]             chk_src_vld,
    input  logic [NUM_SRC-1:0][IDX_W:0]    chk_src_reg,
    input  logic                           wr_en,
    input  logic [IDX_W:0]                 wr_reg,
    input  logic [CLS_W-1:0]               wr_cls,
    output logic                           stall
);

    localparam int REG_W   = IDX_W + 1;
    localparam int NUM_ENT = 2 ** REG_W;

    op_class_e        wr_c;
    op_class_e        chk_c;
    logic [LAT_W-1:0] wr_full;
    logic [LAT_W-1:0] wr_fwd;
    logic             cons_wide;

    logic [LAT_W-1:0] cnt_full [NUM_ENT];
    logic [LAT_W-1:0] cnt_fwd  [NUM_ENT];
    logic [NUM_SRC-1:0] busy;

    always_comb begin
        wr_c      = op_class_e'(wr_cls);
        chk_c     = op_class_e'(chk_cls);
        wr_full   = full_lat(wr_c);
        wr_fwd    = fwd_lat(wr_c);
        cons_wide = is_wide(chk_c);
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic ld;
        if (e == 0) begin : g_hardzero
            assign ld = 1'b0;
        end else begin : g_tracked
            assign ld = wr_en && (wr_reg == REG_W'(e));
        end
        sb_reg_timer i_timer (
            .clk      (clk),
            .rst      (rst),
            .load     (ld),
            .lat_full (wr_full),
            .lat_fwd  (wr_fwd),
            .cnt_full (cnt_full[e]),
            .cnt_fwd  (cnt_fwd[e])
        );
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        sb_src_check #(
            .REG_W   (REG_W),
            .NUM_ENT (NUM_ENT)
        ) i_chk (
            .clk       (clk),
            .rst       (rst),
            .src_vld   (chk_src_vld[s]),
            .src_reg   (chk_src_reg[s]),
            .cons_wide (cons_wide),
            .cnt_full  (cnt_full),
            .cnt_fwd   (cnt_fwd),
            .busy      (busy[s])
        );
    end

    assign stall = |busy;

    assert_int_zero_idle_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_full[0] == '0 && cnt_fwd[0] == '0);

    assert_write_pends_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_reg != '0) |=> cnt_full[$past(wr_reg)] != '0);

    assert_nothing_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (chk_src_vld == '0) |-> !stall);

endmodule

// File: tb/test_sb_scoreboard.sv
module test_sb_scoreboard;

    localparam int NS = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        chk_cls = '0;
    logic [NS-1:0]     chk_src_vld = '0;
    logic [NS-1:0][5:0] chk_src_reg = '0;
    logic              wr_en = 1'b0;
    logic [5:0]        wr_reg = '0;
    logic [3:0]        wr_cls = '0;
    logic              stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sb_scoreboard #(.IDX_W(5), .NUM_SRC(NS)) i_sb_scoreboard (
        .clk(clk), .rst(rst), .chk_cls(chk_cls), .chk_src_vld(chk_src_vld),
        .chk_src_reg(chk_src_reg), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_cls(wr_cls), .stall(stall)
    );

    function automatic int exp_lat(int c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;  3: return 3;
            4: return 4;  5: return 4;  6: return 6;  7: return 3;
            8: return 6;  9: return 2;  10: return 3; 11: return 4;
            12: return 5; 13: return 6; 14: return 7;
            default: return 1;
        endcase
    endfunction

    function automatic bit exp_wide(int c);
        return c == 10 || c == 12 || c == 14;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: stall=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic write(logic [5:0] r, int c);
        wr_en  = 1'b1;
        wr_reg = r;
        wr_cls = 4'(c);
        tick();
        wr_en  = 1'b0;
    endtask

    task automatic one_src(logic [5:0] r, int c);
        chk_src_vld    = 3'b001;
        chk_src_reg[0] = r;
        chk_cls        = 4'(c);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: timeout expected completion");
            finish_run();
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;

        // R9: everything ready after reset
        for (int r = 0; r < 64; r++) begin
            one_src(6'(r), 14);
            check("R9", stall, 1'b0);
        end

        // R1 R2 R3 R4 R5: producer x consumer x offset sweep
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic [5:0] dst;
                int eff;
                string tag;
                dst = (p % 2 == 1) ? 6'h21 : 6'h07;
                eff = (exp_wide(p) && exp_wide(c)) ? exp_lat(p) - 1 : exp_lat(p);
                if (exp_wide(p) && exp_wide(c))      tag = "R4";
                else if (exp_wide(p) || exp_wide(c)) tag = "R5";
                else if (p <= 4)                     tag = "R1";
                else if (p <= 8)                     tag = "R2";
                else                                 tag = "R3";
                write(dst, p);
                for (int k = 0; k < 9; k++) begin
                    one_src(dst, c);
                    check(tag, stall, 1'(k < eff));
                    tick();
                end
            end
        end

        // R6: integer r0 never pending; vector r0 is tracked
        write(6'h00, 14);
        one_src(6'h00, 0);
        check("R6", stall, 1'b0);
        write(6'h20, 14);
        one_src(6'h20, 0);
        check("R6", stall, 1'b1);
        repeat (8) tick();

        // R10: files are independent
        write(6'h05, 14);
        one_src(6'h25, 0);
        check("R10", stall, 1'b0);
        one_src(6'h05, 0);
        check("R10", stall, 1'b1);
        repeat (8) tick();

        // R8: only valid sources count
        write(6'h22, 6);
        chk_cls = 4'd0;
        chk_src_reg[0] = 6'h01;
        chk_src_reg[1] = 6'h22;
        chk_src_reg[2] = 6'h22;
        chk_src_vld = 3'b001; #1;
        check("R8", stall, 1'b0);
        chk_src_vld = 3'b011; #1;
        check("R8", stall, 1'b1);
        chk_src_vld = 3'b101; #1;
        check("R8", stall, 1'b1);
        chk_src_vld = 3'b000; #1;
        check("R8", stall, 1'b0);
        repeat (8) tick();

        // R7: overwrite shortens
        write(6'h23, 14);
        write(6'h23, 0);
        one_src(6'h23, 0);
        check("R7", stall, 1'b1);
        tick();
        check("R7", stall, 1'b0);

        // R7: overwrite lengthens
        write(6'h24, 0);
        write(6'h24, 14);
        one_src(6'h24, 0);
        repeat (6) tick();
        check("R7", stall, 1'b1);
        tick();
        check("R7", stall, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule